// File: doc/BRIEF.md
# Register-Mapped GPIO Port with Per-Pin Interrupts

This block is a general-purpose I/O port of up to 32 pins that sits on a simple 32-bit register bus. Software picks, for each pin, whether it is an input or an output. Software can also read the pin levels and set the levels of the output pins. Each pin can also raise an interrupt. The pin is first synchronised. The configured event is then detected on it: an active level, a single edge of a chosen polarity, or either edge. The event is latched in a pending bit. All enabled pending bits merge into one interrupt line.

Software acknowledges a pin by writing a one to its bit in a write-only clear register. A read-only version register reports the parameter `VERSION`. The either-edge register exists only when `VERSION` is 3 or more. With a lower version it is absent, and every edge-mode pin then triggers on a single edge.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is held, every pin is an input (direction register reads all ones over the pin bits). The enable, edge-select, polarity, either-edge and pending registers all read zero. `pin_oe` is zero and `irq` is low.
- R2: Direction bit n equal to 1 makes pin n an input (`pin_oe[n]`=0). Direction bit n equal to 0 drives the pin (`pin_oe[n]`=1). `pin_out` always equals the value register written at byte offset 0x00, and bit n maps to pin n.
- R3: Reading offset 0x00 returns, for each input pin, its synchronised level, and for each output pin, the written value bit.
- R4: With edge-select bit 0 (offset 0x18), the pin is level-sensitive. Polarity bit 1 (offset 0x1C) means active-high and 0 means active-low. Its pending bit is set on every cycle the active level is present, so a clear while the level persists leaves it pending.
- R5: With edge-select 1 and either-edge 0, polarity 1 latches a rising edge and polarity 0 latches a falling edge. No other transition sets the pending bit.
- R6: When `VERSION` >= 3, the either-edge register at offset 0x24 is writable. With it and edge-select both set to 1, a pin latches both transitions. When `VERSION` < 3, offset 0x24 reads zero and writes to it are ignored. Offset 0x20 reads `VERSION`.
- R7: Writing 1 to a bit at offset 0x14 clears that pending bit, and a 0 bit leaves it unchanged. A new event in the same cycle as its clear wins, and the bit stays pending.
- R8: `irq` is high exactly when some pin is both pending (offset 0x10) and enabled (offset 0x08). Writing zero to the enable register drops `irq` on the next cycle and does not change pending.
- R9: Pending latches events whether or not the pin is enabled. Offset 0x0C reads pending AND enable.
- R10: A pin change driven between clock edges shows in pending after the third following rising edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, captured on the rising edge |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output levels toward the pads |
| pin_oe | output | NPINS | Per-pin output enable, 1 = drive |
| irq | output | 1 | Combined interrupt |

## Verification
Two pairs of functions can meet in a single cycle. The first pair is a detected event and a clear write to the same pending bit. The second pair is a detected event and a write of zero to the enable register. Both are provoked by changing the pins and then timing the bus write so that its rising edge is the third edge after the change, which is the one on which the event latches. The bench then expects the pending bit to survive the clear, and expects pending to hold while `irq` goes low under the zeroed enable.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam logic [7:0] OFS_VALUE  = 8'h00;
   localparam logic [7:0] OFS_DIR    = 8'h04;
   localparam logic [7:0] OFS_ENABLE = 8'h08;
   localparam logic [7:0] OFS_STATUS = 8'h0C;
   localparam logic [7:0] OFS_PEND   = 8'h10;
   localparam logic [7:0] OFS_CLEAR  = 8'h14;
   localparam logic [7:0] OFS_EDGE   = 8'h18;
   localparam logic [7:0] OFS_POL    = 8'h1C;
   localparam logic [7:0] OFS_VER    = 8'h20;
   localparam logic [7:0] OFS_BOTH   = 8'h24;

   localparam int unsigned MIN_BOTH_VERSION = 3;

   // event for one pin: level, single edge or either edge
   function automatic logic pin_event(input logic cur, input logic prev,
                                      input logic edg, input logic pol,
                                      input logic both);
      logic rise, fall;
      rise = cur & ~prev;
      fall = ~cur & prev;
      if (!edg)      return (cur == pol);
      else if (both) return rise | fall;
      else           return pol ? rise : fall;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);
   logic [W-1:0] stage1_q, stage2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1_q <= '0;
         stage2_q <= '0;
      end else begin
         stage1_q <= async_i;
         stage2_q <= stage1_q;
      end
   end

   assign sync_o = stage2_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
   import gpio_irq_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur_i,
   input  logic [W-1:0] edge_sel_i,
   input  logic [W-1:0] pol_i,
   input  logic [W-1:0] both_i,
   output logic [W-1:0] evt_o
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cur_i;
   end

   for (genvar g = 0; g < W; g++) begin : g_pin
      assign evt_o[g] = pin_event(cur_i[g], prev_q[g], edge_sel_i[g],
                                  pol_i[g], both_i[g]);
   end
endmodule

// File: rtl/gpio_pend.sv
module gpio_pend #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] clr_mask_i,
   output logic [W-1:0] pend_o
);
   logic [W-1:0] pend_q;
   logic [W-1:0] clr_eff;

   assign clr_eff = clr_we_i ? clr_mask_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_eff) | evt_i;
   end

   assign pend_o = pend_q;

   // R10
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((pend_o & $past(evt_i)) == $past(evt_i)));

   // R7
   pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && ((clr_mask_i & ~evt_i) != '0))
      |=> ((pend_o & $past(clr_mask_i & ~evt_i)) == '0));

   // R9
   pend_nospur_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_o & ~$past(pend_o) & ~$past(evt_i)) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPINS   = 32,
   parameter int unsigned VERSION = 3,
   parameter int unsigned ADDR_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq
);
   localparam bit HAS_BOTH = (VERSION >= MIN_BOTH_VERSION);

   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("gpio_irq_port: NPINS must lie in 1..32");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("gpio_irq_port: ADDR_W must be at least 6");
   end

   logic [NPINS-1:0] val_q, dir_q, en_q, edge_q, pol_q, both_r;
   logic [NPINS-1:0] sync_lvl, evt, pend;
   logic [NPINS-1:0] wdat;
   logic             wr_val, wr_dir, wr_en, wr_edge, wr_pol, wr_both, wr_clr;

   assign wdat    = bus_wdata[NPINS-1:0];
   assign wr_val  = bus_we && (bus_addr == OFS_VALUE[ADDR_W-1:0]);
   assign wr_dir  = bus_we && (bus_addr == OFS_DIR[ADDR_W-1:0]);
   assign wr_en   = bus_we && (bus_addr == OFS_ENABLE[ADDR_W-1:0]);
   assign wr_edge = bus_we && (bus_addr == OFS_EDGE[ADDR_W-1:0]);
   assign wr_pol  = bus_we && (bus_addr == OFS_POL[ADDR_W-1:0]);
   assign wr_both = bus_we && (bus_addr == OFS_BOTH[ADDR_W-1:0]);
   assign wr_clr  = bus_we && (bus_addr == OFS_CLEAR[ADDR_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q  <= '0;
         dir_q  <= '1;
         en_q   <= '0;
         edge_q <= '0;
         pol_q  <= '0;
      end else begin
         if (wr_val)  val_q  <= wdat;
         if (wr_dir)  dir_q  <= wdat;
         if (wr_en)   en_q   <= wdat;
         if (wr_edge) edge_q <= wdat;
         if (wr_pol)  pol_q  <= wdat;
      end
   end

   if (HAS_BOTH) begin : g_both
      logic [NPINS-1:0] both_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       both_q <= '0;
         else if (wr_both) both_q <= wdat;
      end
      assign both_r = both_q;
   end else begin : g_no_both
      assign both_r = '0;
   end

   gpio_sync #(.W(NPINS)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(sync_lvl));

   gpio_evt_detect #(.W(NPINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .cur_i(sync_lvl), .edge_sel_i(edge_q),
      .pol_i(pol_q), .both_i(both_r), .evt_o(evt));

   gpio_pend #(.W(NPINS)) u_pend (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_we_i(wr_clr),
      .clr_mask_i(wdat), .pend_o(pend));

   assign pin_out = val_q;
   assign pin_oe  = ~dir_q;
   assign irq     = |(pend & en_q);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == OFS_VALUE[ADDR_W-1:0])
         bus_rdata[NPINS-1:0] = (dir_q & sync_lvl) | (~dir_q & val_q);
      else if (bus_addr == OFS_DIR[ADDR_W-1:0])
         bus_rdata[NPINS-1:0] = dir_q;
      else if (bus_addr == OFS_ENABLE[ADDR_W-1:0])
         bus_rdata[NPINS-1:0] = en_q;
      else if (bus_addr == OFS_STATUS[ADDR_W-1:0])
         bus_rdata[NPINS-1:0] = pend & en_q;
      else if (bus_addr == OFS_PEND[ADDR_W-1:0])
         bus_rdata[NPINS-1:0] = pend;
      else if (bus_addr == OFS_EDGE[ADDR_W-1:0])
         bus_rdata[NPINS-1:0] = edge_q;
      else if (bus_addr == OFS_POL[ADDR_W-1:0])
         bus_rdata[NPINS-1:0] = pol_q;
      else if (bus_addr == OFS_BOTH[ADDR_W-1:0])
         bus_rdata[NPINS-1:0] = both_r;
      else if (bus_addr == OFS_VER[ADDR_W-1:0])
         bus_rdata = VERSION;
   end

   // R8
   mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wdat == '0)) |=> !irq);
endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
   localparam int CLK_P = 10;
   localparam int NP    = 4;
   localparam logic [3:0] M = 4'hF;

   localparam logic [5:0] A_VAL = 6'h00, A_DIR = 6'h04, A_EN = 6'h08,
      A_STAT = 6'h0C, A_PEND = 6'h10, A_CLR = 6'h14, A_EDGE = 6'h18,
      A_POL = 6'h1C, A_VER = 6'h20, A_BOTH = 6'h24;

   logic clk = 0, rst_n = 0, bus_we = 0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, rdat, rdat2;
   logic [NP-1:0] pins = '0, pout, poe, pout2, poe2;
   logic irq_a, irq_b;
   int checks = 0, fails = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   gpio_irq_port #(.NPINS(NP), .VERSION(3), .ADDR_W(6)) i_gpio_irq_port (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdat), .pin_in(pins),
      .pin_out(pout), .pin_oe(poe), .irq(irq_a));

   gpio_irq_port #(.NPINS(NP), .VERSION(2), .ADDR_W(6)) i_gpio_irq_port_v2 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdat2), .pin_in(pins),
      .pin_out(pout2), .pin_oe(poe2), .irq(irq_b));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d, output logic [31:0] d2);
      bus_addr = a; #1;
      d = rdat; d2 = rdat2;
   endtask

   task automatic settle_pins(input logic [3:0] p);
      @(negedge clk); pins = p;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] r, r2;
      logic [3:0] pend0, expn, ev2;
      // R1 reset state
      repeat (2) @(negedge clk);
      rd(A_DIR, r, r2);  chk("R1 dir", r, 32'hF);
      rd(A_EN, r, r2);   chk("R1 enable", r, 0);
      rd(A_EDGE, r, r2); chk("R1 edge", r, 0);
      rd(A_POL, r, r2);  chk("R1 pol", r, 0);
      rd(A_BOTH, r, r2); chk("R1 both", r, 0);
      rd(A_PEND, r, r2); chk("R1 pending", r, 0);
      chk("R1 pin_oe", {28'd0, poe}, 0);
      chk("R1 irq", {31'd0, irq_a}, 0);
      rd(A_VER, r, r2);  chk("R6 version v3", r, 3); chk("R6 version v2", r2, 2);
      @(negedge clk); rst_n = 1;

      // R2 / R3 direction and value sweep
      wr(A_DIR, 32'h5);
      for (int v = 0; v < 16; v++) begin
         for (int p = 0; p < 16; p++) begin
            wr(A_VAL, v);
            settle_pins(4'(p));
            chk("R2 pin_oe", {28'd0, poe}, 32'hA);
            chk("R2 pin_out", {28'd0, pout}, v);
            rd(A_VAL, r, r2);
            chk("R3 value read", r, (p & 5) | (v & 32'hA));
         end
      end
      wr(A_DIR, 32'hF);
      chk("R2 all inputs", {28'd0, poe}, 0);

      // R4 R5 R6 mode sweep: 0 lvl-high 1 lvl-low 2 rise 3 fall 4 both
      for (int mode = 0; mode < 5; mode++) begin
         logic [3:0] polm;
         polm = (mode == 0 || mode == 2 || mode == 4) ? M : 4'h0;
         wr(A_EDGE, (mode >= 2) ? 32'hF : 32'h0);
         wr(A_POL, polm);
         wr(A_BOTH, (mode == 4) ? 32'hF : 32'h0);
         if (mode == 4) begin
            rd(A_BOTH, r, r2);
            chk("R6 both writable v3", r, 32'hF);
            chk("R6 both ignored v2", r2, 0);
         end
         for (int s = 0; s < 16; s++) begin
            for (int e = 0; e < 16; e++) begin
               settle_pins(4'(s));
               wr(A_CLR, 32'hF);
               rd(A_PEND, r, r2);
               pend0 = (mode < 2) ? ((polm ~^ 4'(s)) & M) : 4'h0;
               chk(mode < 2 ? "R4 level re-set after clear" : "R5 clear in edge mode",
                   r, pend0);
               settle_pins(4'(e));
               rd(A_PEND, r, r2);
               case (mode)
                  0, 1: expn = pend0 | (polm ~^ 4'(e));
                  2: expn = ~4'(s) & 4'(e);
                  3: expn = 4'(s) & ~4'(e);
                  default: expn = 4'(s) ^ 4'(e);
               endcase
               ev2 = ~4'(s) & 4'(e);
               if (mode < 2) chk("R4 level events", r, expn);
               else if (mode < 4) chk("R5 single edge", r, expn);
               else begin
                  chk("R6 either edge v3", r, expn);
                  chk("R6 rise only v2", r2, ev2);
               end
            end
         end
      end

      // rising mode for remaining tests
      wr(A_BOTH, 0); wr(A_EDGE, 32'hF); wr(A_POL, 32'hF);

      // R10 latency
      settle_pins(4'h0); wr(A_CLR, 32'hF);
      @(negedge clk); pins = 4'h3;
      @(negedge clk); @(negedge clk);
      rd(A_PEND, r, r2); chk("R10 not after two edges", r, 0);
      @(negedge clk);
      rd(A_PEND, r, r2); chk("R10 after third edge", r, 32'h3);

      // R7 partial clear
      settle_pins(4'h0); wr(A_CLR, 32'hF);
      settle_pins(4'hF);
      wr(A_CLR, 32'h5);
      rd(A_PEND, r, r2); chk("R7 partial clear", r, 32'hA);
      wr(A_CLR, 32'h0);
      rd(A_PEND, r, r2); chk("R7 zero clear no effect", r, 32'hA);

      // R8 R9 enable sweep, pending 1010
      for (int en = 0; en < 16; en++) begin
         wr(A_EN, en);
         @(negedge clk);
         chk("R8 irq vs enable", {31'd0, irq_a}, ((en & 10) != 0) ? 1 : 0);
         rd(A_STAT, r, r2); chk("R9 status", r, en & 10);
         rd(A_PEND, r, r2); chk("R9 pending kept", r, 32'hA);
      end

      // R9 latch while disabled
      wr(A_EN, 0);
      settle_pins(4'h0); wr(A_CLR, 32'hF);
      settle_pins(4'h6);
      rd(A_PEND, r, r2); chk("R9 latched while disabled", r, 32'h6);
      chk("R9 irq low disabled", {31'd0, irq_a}, 0);

      // R7 coincident clear and event
      settle_pins(4'h0); wr(A_CLR, 32'hF);
      @(negedge clk); pins = 4'hF;
      @(negedge clk);
      wr(A_CLR, 32'hF);
      rd(A_PEND, r, r2); chk("R7 event beats clear", r, 32'hF);

      // R8 coincident mask and event
      wr(A_EN, 32'hF);
      settle_pins(4'h0); wr(A_CLR, 32'hF);
      @(negedge clk);
      chk("R8 irq low no pending", {31'd0, irq_a}, 0);
      pins = 4'h9;
      @(negedge clk);
      wr(A_EN, 0);
      @(negedge clk);
      chk("R8 irq masked", {31'd0, irq_a}, 0);
      rd(A_PEND, r, r2); chk("R8 pending intact under mask", r, 32'h9);
      wr(A_EN, 32'hF);
      @(negedge clk);
      chk("R8 irq after re-enable", {31'd0, irq_a}, 1);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule